// File: doc/BRIEF.md
# Inter-Core Interrupt Generator

This unit lets the cores of a multi-core cluster interrupt one another. A single shared command port carries a command code, a core-number argument and the number of the core that issues the command. For every target core the unit keeps a register with one bit per possible sender. Each core receives one interrupt line, and that line is the OR of its sender register.

A core raises an interrupt on a peer by naming that peer. A core that wants to avoid a redundant interrupt can first ask whether the peer already has one pending. The receiving core asks which cores signalled it. It then acknowledges each sender separately. When several cores target the same receiver, their requests merge onto one line, but each request keeps its own bit.

Results of the two query commands appear on a readback bus in the cycle after the command. The readback is qualified by a valid flag.

Top module: `ipi_unit`

## Requirements
- R1: After reset, every interrupt output is low, every sender register is empty, and the readback valid flag is low.
- R2: A raise command (code 1) with a valid target T and a valid issuer S, where S differs from T, sets bit S of the register of T. The interrupt output of T is high from the cycle after the command.
- R3: A raise command whose target equals its issuer changes no register and no interrupt output.
- R4: A pending query (code 2) with target T returns, in the next cycle, readback valid high and readback bit 0 equal to whether T has any sender bit set. All other readback bits are zero.
- R5: A source query (code 3) returns, in the next cycle, the register of the issuing core with readback valid high. Bit k of the readback is set when core k has an unacknowledged interrupt toward the issuer.
- R6: Raises from several senders to one target drive a single interrupt line. The target's register then holds one bit per sender.
- R7: An acknowledge command (code 4) with sender number K, issued by core R, clears only bit K of the register of R.
- R8: An interrupt output stays high for as long as any bit of its register is set. It falls in the cycle after the last bit is cleared.
- R9: A core number at or above the core count, whether given as the argument or as the issuer, makes a raise or acknowledge have no effect. A pending query of such a target returns 0. Codes 0 and 5 to 7 have no effect.
- R10: While the command valid input is low, no state changes and readback valid is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 3 | 1 raise, 2 pending query, 3 source query, 4 acknowledge |
| cmd_arg | input | ID_W | Target core (raise, pending query) or sender core (acknowledge) |
| cmd_issuer | input | ID_W | Number of the core issuing the command |
| rd_valid | output | 1 | Readback data valid (cycle after a query) |
| rd_data | output | NCORES | Readback value, zero when not valid |
| irq_out | output | NCORES | Level interrupt to each core |

## Verification
The bench targets four faults. The first is a self-directed raise: a unit that accepted it would leave a core interrupting itself, and that line would never clear through its own acknowledge. The second is coalescing: a unit that stored only one sender per target would lose a bit, or an acknowledge would wipe all senders at once, so an interrupt would be dropped or left stuck. The third is acknowledges from the wrong receiver and core numbers outside the range: these must leave the lines untouched, while a decoder that truncated the numbers would alias onto a real core. The fourth is the readback timing and the zeroing of the unused readback bits: a design that got these wrong would return stale or garbage values to the polling core.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_RAISE = 3'd1,
        OP_PEEK  = 3'd2,
        OP_WHO   = 3'd3,
        OP_ACK   = 3'd4
    } ipi_op_e;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int ID_W   = 3
) (
    input  logic                     valid_i,
    input  logic [2:0]               code_i,
    input  logic [ID_W-1:0]          arg_i,
    input  logic [ID_W-1:0]          issuer_i,
    output logic [NCORES*NCORES-1:0] set_o,
    output logic [NCORES*NCORES-1:0] clr_o,
    output logic                     peek_o,
    output logic                     who_o,
    output logic                     arg_ok_o,
    output logic                     issuer_ok_o
);
    localparam logic [ID_W:0] NLIM = (ID_W+1)'(NCORES);

    ipi_op_e op;

    always_comb begin
        op          = ipi_op_e'(code_i);
        arg_ok_o    = {1'b0, arg_i} < NLIM;
        issuer_ok_o = {1'b0, issuer_i} < NLIM;
        peek_o      = valid_i && (op == OP_PEEK);
        who_o       = valid_i && (op == OP_WHO);
        set_o       = '0;
        clr_o       = '0;
        for (int t = 0; t < NCORES; t++) begin
            for (int s = 0; s < NCORES; s++) begin
                // raise: row = target (arg), column = sender (issuer)
                set_o[t*NCORES+s] = valid_i && (op == OP_RAISE) && arg_ok_o && issuer_ok_o
                                    && (arg_i == ID_W'(t)) && (issuer_i == ID_W'(s)) && (t != s);
                // acknowledge: row = receiver (issuer), column = sender (arg)
                clr_o[t*NCORES+s] = valid_i && (op == OP_ACK) && arg_ok_o && issuer_ok_o
                                    && (issuer_i == ID_W'(t)) && (arg_i == ID_W'(s));
            end
        end
    end
endmodule

// File: rtl/ipi_row.sv
module ipi_row #(
    parameter int NCORES = 4,
    parameter int SELF   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCORES-1:0] set_i,
    input  logic [NCORES-1:0] clr_i,
    output logic [NCORES-1:0] bits_o,
    output logic              pend_o
);
    typedef struct packed {
        logic [NCORES-1:0] bits;
    } row_t;

    row_t row_d, row_q;

    always_comb begin
        row_d = row_q;
        // a raise outranks an acknowledge on the same bit
        row_d.bits = (row_q.bits & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign bits_o = row_q.bits;
    assign pend_o = |row_q.bits;

    p_no_self_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !row_q.bits[SELF]);

    for (genvar k = 0; k < NCORES; k++) begin : g_chk
        p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> row_q.bits[k]);
        p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !row_q.bits[k]);
        p_bit_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[k] && !set_i[k]) |=> $stable(row_q.bits[k]));
    end
endmodule

// File: rtl/ipi_readback.sv
module ipi_readback #(
    parameter int NCORES = 4,
    parameter int ID_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     peek_i,
    input  logic                     who_i,
    input  logic                     arg_ok_i,
    input  logic                     issuer_ok_i,
    input  logic [ID_W-1:0]          arg_i,
    input  logic [ID_W-1:0]          issuer_i,
    input  logic [NCORES-1:0]        pend_i,
    input  logic [NCORES*NCORES-1:0] bits_i,
    output logic                     rd_valid_o,
    output logic [NCORES-1:0]        rd_data_o
);
    typedef struct packed {
        logic              valid;
        logic [NCORES-1:0] data;
    } rb_t;

    rb_t rb_d, rb_q;

    always_comb begin
        rb_d       = '0;
        rb_d.valid = peek_i || who_i;
        for (int t = 0; t < NCORES; t++) begin
            if (peek_i && arg_ok_i && (arg_i == ID_W'(t)))
                rb_d.data[0] = pend_i[t];
            if (who_i && issuer_ok_i && (issuer_i == ID_W'(t)))
                rb_d.data = bits_i[t*NCORES +: NCORES];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rb_q <= '0;
        else        rb_q <= rb_d;
    end

    assign rd_valid_o = rb_q.valid;
    assign rd_data_o  = rb_q.data;

    p_query_answers_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (peek_i || who_i) |=> rd_valid_o);
    p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(peek_i || who_i) |=> (!rd_valid_o && rd_data_o == '0));
    p_peek_single_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        peek_i |=> (rd_data_o[NCORES-1:1] == '0));
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
    import ipi_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int ID_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [ID_W-1:0]   cmd_arg,
    input  logic [ID_W-1:0]   cmd_issuer,
    output logic              rd_valid,
    output logic [NCORES-1:0] rd_data,
    output logic [NCORES-1:0] irq_out
);
    localparam int NBITS = NCORES * NCORES;

    logic [NBITS-1:0]  set_m, clr_m, bits_m;
    logic [NCORES-1:0] pend;
    logic              peek, who, arg_ok, issuer_ok;

    ipi_decode #(.NCORES(NCORES), .ID_W(ID_W)) u_dec (
        .valid_i    (cmd_valid),
        .code_i     (cmd_code),
        .arg_i      (cmd_arg),
        .issuer_i   (cmd_issuer),
        .set_o      (set_m),
        .clr_o      (clr_m),
        .peek_o     (peek),
        .who_o      (who),
        .arg_ok_o   (arg_ok),
        .issuer_ok_o(issuer_ok)
    );

    for (genvar t = 0; t < NCORES; t++) begin : g_row
        ipi_row #(.NCORES(NCORES), .SELF(t)) u_row (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_m[t*NCORES +: NCORES]),
            .clr_i (clr_m[t*NCORES +: NCORES]),
            .bits_o(bits_m[t*NCORES +: NCORES]),
            .pend_o(pend[t])
        );
    end

    ipi_readback #(.NCORES(NCORES), .ID_W(ID_W)) u_rb (
        .clk        (clk),
        .rst_n      (rst_n),
        .peek_i     (peek),
        .who_i      (who),
        .arg_ok_i   (arg_ok),
        .issuer_ok_i(issuer_ok),
        .arg_i      (cmd_arg),
        .issuer_i   (cmd_issuer),
        .pend_i     (pend),
        .bits_i     (bits_m),
        .rd_valid_o (rd_valid),
        .rd_data_o  (rd_data)
    );

    assign irq_out = pend;

    p_self_raise_inert_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 3'd1 && cmd_arg == cmd_issuer) |=> $stable(irq_out));
    p_idle_inert_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(irq_out));
    p_out_of_range_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && ({1'b0, cmd_arg} >= (ID_W+1)'(NCORES))) |=> $stable(irq_out));
endmodule

// File: tb/ipi_unit_test.sv
module ipi_unit_test;
    localparam int N    = 4;
    localparam int ID_W = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [2:0]      cmd_code = '0;
    logic [ID_W-1:0] cmd_arg = '0;
    logic [ID_W-1:0] cmd_issuer = '0;
    logic            rd_valid;
    logic [N-1:0]    rd_data;
    logic [N-1:0]    irq_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ipi_unit #(.NCORES(N), .ID_W(ID_W)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_arg(cmd_arg), .cmd_issuer(cmd_issuer), .rd_valid(rd_valid),
        .rd_data(rd_data), .irq_out(irq_out)
    );

    typedef struct packed {
        logic       v;
        logic [2:0] code;
        logic [2:0] arg;
        logic [2:0] iss;
        logic       e_rv;
        logic [3:0] e_rd;
        logic [3:0] e_irq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd0, 3'd0, 3'd0, 1'b0, 4'b0000, 4'b0000}, // R9 no-op code
        '{1'b1, 3'd1, 3'd2, 3'd0, 1'b0, 4'b0000, 4'b0100}, // R2 0 -> 2
        '{1'b1, 3'd1, 3'd2, 3'd3, 1'b0, 4'b0000, 4'b0100}, // R6 3 -> 2 merges
        '{1'b1, 3'd2, 3'd2, 3'd1, 1'b1, 4'b0001, 4'b0100}, // R4 pending of 2
        '{1'b1, 3'd3, 3'd0, 3'd2, 1'b1, 4'b1001, 4'b0100}, // R5 R6 sources of 2
        '{1'b1, 3'd1, 3'd1, 3'd1, 1'b0, 4'b0000, 4'b0100}, // R3 self raise
        '{1'b1, 3'd2, 3'd1, 3'd0, 1'b1, 4'b0000, 4'b0100}, // R3 core 1 clean
        '{1'b1, 3'd4, 3'd3, 3'd2, 1'b0, 4'b0000, 4'b0100}, // R7 ack sender 3
        '{1'b1, 3'd3, 3'd0, 3'd2, 1'b1, 4'b0001, 4'b0100}, // R7 only bit 3 gone
        '{1'b1, 3'd4, 3'd0, 3'd2, 1'b0, 4'b0000, 4'b0000}, // R8 last ack drops line
        '{1'b1, 3'd1, 3'd5, 3'd0, 1'b0, 4'b0000, 4'b0000}, // R9 target 5
        '{1'b1, 3'd1, 3'd0, 3'd6, 1'b0, 4'b0000, 4'b0000}, // R9 issuer 6
        '{1'b1, 3'd1, 3'd0, 3'd1, 1'b0, 4'b0000, 4'b0001}, // R2 1 -> 0
        '{1'b1, 3'd4, 3'd1, 3'd3, 1'b0, 4'b0000, 4'b0001}, // R7 wrong receiver
        '{1'b1, 3'd3, 3'd0, 3'd0, 1'b1, 4'b0010, 4'b0001}, // R5 sources of 0
        '{1'b0, 3'd1, 3'd3, 3'd0, 1'b0, 4'b0000, 4'b0001}, // R10 not valid
        '{1'b1, 3'd2, 3'd3, 3'd0, 1'b1, 4'b0000, 4'b0001}, // R10 core 3 clean
        '{1'b1, 3'd2, 3'd6, 3'd0, 1'b1, 4'b0000, 4'b0001}  // R9 pending of 6
    };

    task automatic chk(input string req, input int got, input int exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic issue(input logic v, input logic [2:0] c, input logic [2:0] a,
                         input logic [2:0] i);
        cmd_valid  = v;
        cmd_code   = c;
        cmd_arg    = a;
        cmd_issuer = i;
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R1 irq", int'(irq_out), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            issue(VEC[k].v, VEC[k].code, VEC[k].arg, VEC[k].iss);
            chk($sformatf("vec%0d rd_valid", k), int'(rd_valid), int'(VEC[k].e_rv));
            chk($sformatf("vec%0d rd_data", k), int'(rd_data), int'(VEC[k].e_rd));
            chk($sformatf("vec%0d irq", k), int'(irq_out), int'(VEC[k].e_irq));
        end

        // R6: three senders toward core 0 share one line
        issue(1'b1, 3'd1, 3'd0, 3'd2);
        issue(1'b1, 3'd1, 3'd0, 3'd3);
        chk("R6 irq", int'(irq_out), 4'b0001);
        issue(1'b1, 3'd3, 3'd0, 3'd0);
        chk("R6 bitmap", int'(rd_data), 4'b1110);
        // R7/R8: line stays while bits remain
        issue(1'b1, 3'd4, 3'd2, 3'd0);
        issue(1'b1, 3'd4, 3'd1, 3'd0);
        chk("R8 still high", int'(irq_out), 4'b0001);
        issue(1'b1, 3'd4, 3'd3, 3'd0);
        chk("R8 low", int'(irq_out), 4'b0000);

        // R1: reset in the middle of activity
        issue(1'b1, 3'd1, 3'd3, 3'd1);
        chk("R2 pre-reset", int'(irq_out), 4'b1000);
        issue(1'b1, 3'd3, 3'd0, 3'd3);
        rst_n = 1'b0;
        #1;
        chk("R1 irq async", int'(irq_out), 0);
        chk("R1 rd_valid async", int'(rd_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        issue(1'b1, 3'd3, 3'd0, 3'd3);
        chk("R1 bitmap cleared", int'(rd_data), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule